// File: doc/BRIEF.md
# Programmable Macrocell Register with Initialization Steering

This block models the storage element of one programmable-logic macrocell. A data bit is captured on the rising clock edge when a selected clock-enable is true. The enable is picked by a static two-bit field from the per-cell enable term, its complement, a shared term, or a constant one. A group-wide initialization term and two per-cell product-term lines drive the cell's set and reset behaviour. A per-cell exchange option makes the set lines clear the cell and the clear lines set it. The same option fixes the value the cell takes at power-up.

A synchronous active-low power-on input loads the configured power-up value and starts a hold window. For a configurable number of clock edges after that input is released, the register ignores data and keeps its power-up value. The set and clear lines act on the output at once, without waiting for a clock edge. The register also takes the forced value at every rising edge while a line is active, so the value stays after the line is released, provided the pulse spans at least one rising edge. The configuration inputs are assumed to change only while the power-on input is low.

Top module: `mc_cell_reg`

## Requirements
- R1: On a rising edge with `rst_n` low, `q` becomes 1 when `cfg_init_en`=1 and `cfg_swap`=1, and 0 in every other configuration.
- R2: After `rst_n` returns high, the first `cfg_delay` rising edges do not load `d`. The next edge with the enable true loads it. `cfg_delay`=0 gives no hold window.
- R3: The enable is chosen by `cfg_ce_sel`: 0 selects `cell_term`, 1 selects the inverse of `cell_term`, 2 selects `shared_term`, and 3 selects a constant 1.
- R4: On a rising edge where the selected enable is 0, `q` keeps its value.
- R5: With `cfg_init_en`=1 and `cfg_swap`=0, `grp_init` or `sr_pt_clr` high clears `q` within the same cycle. The value 0 is kept after the line is released.
- R6: With `cfg_init_en`=1 and `cfg_swap`=0, `sr_pt_set` high and both clear lines low set `q` within the same cycle.
- R7: With `cfg_swap`=1, `grp_init` or `sr_pt_clr` sets `q`, and `sr_pt_set` clears `q`.
- R8: When a set line and a clear line are high together, the `grp_init`/`sr_pt_clr` line takes priority. `q` is 0 when unswapped and 1 when swapped.
- R9: With `cfg_init_en`=0, `grp_init`, `sr_pt_set` and `sr_pt_clr` have no effect on `q`.
- R10: While a set or clear line is active, `q` shows the forced value whatever the enable and `d` are, including across rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Synchronous active-low power-on input |
| d | input | 1 | Data bit |
| shared_term | input | 1 | Shared enable/clock term |
| cell_term | input | 1 | Per-cell initialization/enable term |
| grp_init | input | 1 | Group initialization term, in the clear role when unswapped |
| sr_pt_set | input | 1 | Per-cell product-term line, in the set role when unswapped |
| sr_pt_clr | input | 1 | Per-cell product-term line, in the clear role when unswapped |
| cfg_ce_sel | input | 2 | Enable source select |
| cfg_swap | input | 1 | Exchanges the set and clear roles |
| cfg_init_en | input | 1 | Enables the set/clear lines |
| cfg_delay | input | DLY_W | Number of edges ignored after power-on |
| q | output | 1 | Register output |

## Verification
Two functions can fall in the same cycle. In one case a set or clear line is active on a clock edge where the enable is true and `d` holds the opposite value. In the other, the set line and the clear line rise together. The bench drives both cases with the cell unswapped and with it swapped. It checks `q` just after the line rises, before any edge, and again after the edge. The forced value must win in every case. The clear-role line must take priority when both are high.

// File: rtl/mc_cell_pkg.sv
// Package: shared types for the macrocell register.
// Assumes: nothing beyond IEEE 1800-2017.
package mc_cell_pkg;
    typedef enum logic [1:0] {
        CE_CELL     = 2'd0,
        CE_CELL_INV = 2'd1,
        CE_SHARED   = 2'd2,
        CE_ALWAYS   = 2'd3
    } ce_sel_e;
endpackage

// File: rtl/mc_ce_mux.sv
// Module: 4:1 clock-enable source selector.
// Assumes: sel is static during operation.
module mc_ce_mux
    import mc_cell_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       cell_term,
    input  logic       shared_term,
    output logic       ce
);
    // Pick the enable source from the select code.
    always_comb begin
        unique case (ce_sel_e'(sel))
            CE_CELL:     ce = cell_term;
            CE_CELL_INV: ce = ~cell_term;
            CE_SHARED:   ce = shared_term;
            default:     ce = 1'b1;
        endcase
    end
endmodule

// File: rtl/mc_sr_steer.sv
// Module: set/clear steering. It merges the group term with the per-cell
// lines, applies the role exchange, and derives the power-up value.
// Assumes: swap and init_en are static.
module mc_sr_steer (
    input  logic grp_init,
    input  logic pt_set,
    input  logic pt_clr,
    input  logic swap,
    input  logic init_en,
    output logic force_en,
    output logic force_val,
    output logic pwr_val
);
    logic line_clr;
    logic line_set;

    // Merge the raw lines; the clear-role line takes priority.
    always_comb begin
        line_clr  = grp_init | pt_clr;
        line_set  = pt_set;
        force_en  = init_en & (line_clr | line_set);
        force_val = line_clr ? swap : ~swap;
        pwr_val   = init_en & swap;
    end
endmodule

// File: rtl/mc_hold_timer.sv
// Module: counts down the edges to ignore after power-on.
// Assumes: load_val is stable while rst_n is low.
module mc_hold_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] load_val,
    output logic             holding
);
    logic [DLY_W-1:0] cnt;

    // Load on power-on, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign holding = (cnt != '0);

    // R2
    cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/mc_cell_reg.sv
// Module: configurable macrocell register (top). It has a selected
// clock-enable, set/clear lines that act at once, and a power-up value
// and hold window that depend on the configuration.
// Assumes: cfg_* inputs change only while rst_n is low. Set/clear pulses
// are kept only when they span a rising edge.
module mc_cell_reg #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d,
    input  logic             shared_term,
    input  logic             cell_term,
    input  logic             grp_init,
    input  logic             sr_pt_set,
    input  logic             sr_pt_clr,
    input  logic [1:0]       cfg_ce_sel,
    input  logic             cfg_swap,
    input  logic             cfg_init_en,
    input  logic [DLY_W-1:0] cfg_delay,
    output logic             q
);
    logic ce;
    logic force_en;
    logic force_val;
    logic pwr_val;
    logic holding;
    logic q_reg;

    mc_ce_mux u_ce (
        .sel         (cfg_ce_sel),
        .cell_term   (cell_term),
        .shared_term (shared_term),
        .ce          (ce)
    );

    mc_sr_steer u_sr (
        .grp_init  (grp_init),
        .pt_set    (sr_pt_set),
        .pt_clr    (sr_pt_clr),
        .swap      (cfg_swap),
        .init_en   (cfg_init_en),
        .force_en  (force_en),
        .force_val (force_val),
        .pwr_val   (pwr_val)
    );

    mc_hold_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (cfg_delay),
        .holding  (holding)
    );

    // Storage: power-up load, forced capture, or enabled data load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_reg <= pwr_val;
        else if (force_en)
            q_reg <= force_val;
        else if (!holding && ce)
            q_reg <= d;
    end

    // Output: the set/clear lines override the register at once.
    assign q = force_en ? force_val : q_reg;

    // R5
    clr_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_init_en && !cfg_swap && (grp_init || sr_pt_clr)) |-> !q);
    // R7
    swap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_init_en && cfg_swap && (grp_init || sr_pt_clr)) |-> q);
    // R6
    set_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_init_en && !cfg_swap && sr_pt_set && !grp_init && !sr_pt_clr) |-> q);
    // R2
    hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !force_en) |=> $stable(q_reg));
endmodule

// File: tb/sim_mc_cell_reg.sv
module sim_mc_cell_reg;
    localparam int DLY_W = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d = 1'b0, shared_term = 1'b0, cell_term = 1'b0;
    logic grp_init = 1'b0, sr_pt_set = 1'b0, sr_pt_clr = 1'b0;
    logic [1:0] cfg_ce_sel = 2'd3;
    logic cfg_swap = 1'b0, cfg_init_en = 1'b1;
    logic [DLY_W-1:0] cfg_delay = '0;
    logic q;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    mc_cell_reg #(.DLY_W(DLY_W)) u0 (.*);

    // Vector: {ce_sel[1:0], cell_term, shared_term, d, expected q}
    localparam logic [5:0] VEC [10] = '{
        6'b110011, 6'b110000, 6'b001011, 6'b000001, 6'b010000,
        6'b011010, 6'b100111, 6'b101001, 6'b100100, 6'b001011
    };

    task automatic chk(input string req, input logic exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    task automatic edge_step();
        @(negedge clk);
    endtask

    task automatic power_on(input logic sw, input logic en, input int dly);
        @(negedge clk);
        rst_n = 1'b0; cfg_swap = sw; cfg_init_en = en; cfg_delay = DLY_W'(dly);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: q=%b expected %b", q, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 power-up values
        power_on(1'b1, 1'b0, 0); chk("R1 no init", 1'b0);
        power_on(1'b1, 1'b1, 0); chk("R1 swapped", 1'b1);
        power_on(1'b0, 1'b1, 0); chk("R1 unswapped", 1'b0);

        // R3 and R4 table walk
        foreach (VEC[i]) begin
            cfg_ce_sel = VEC[i][5:4]; cell_term = VEC[i][3];
            shared_term = VEC[i][2]; d = VEC[i][1];
            edge_step();
            chk($sformatf("R3/R4 vec%0d", i), VEC[i][0]);
        end

        // R2 hold window of three edges
        cfg_ce_sel = 2'd3; d = 1'b1;
        power_on(1'b0, 1'b1, 3);
        for (int k = 0; k < 3; k++) begin
            edge_step(); chk("R2 held", 1'b0);
        end
        edge_step(); chk("R2 load after window", 1'b1);
        power_on(1'b0, 1'b1, 0); d = 1'b1;
        edge_step(); chk("R2 zero delay", 1'b1);

        // R5 and R10 clear line against enabled data
        sr_pt_clr = 1'b1; #1 chk("R5 immediate clear", 1'b0);
        edge_step(); chk("R10 clear over d", 1'b0);
        sr_pt_clr = 1'b0; #1 chk("R5 retained", 1'b0);
        edge_step();
        grp_init = 1'b1; #1 chk("R5 group clear", 1'b0);
        edge_step(); grp_init = 1'b0;

        // R6 and R10 set line
        d = 1'b0; edge_step();
        sr_pt_set = 1'b1; #1 chk("R6 immediate set", 1'b1);
        edge_step(); chk("R10 set over d", 1'b1);
        sr_pt_set = 1'b0; #1 chk("R6 retained", 1'b1);

        // R8 both lines high, unswapped
        sr_pt_set = 1'b1; sr_pt_clr = 1'b1; #1 chk("R8 unswapped", 1'b0);
        edge_step(); sr_pt_set = 1'b0; sr_pt_clr = 1'b0;

        // R7 swapped roles
        power_on(1'b1, 1'b1, 0); d = 1'b0;
        edge_step(); chk("R7 load 0", 1'b0);
        grp_init = 1'b1; #1 chk("R7 group sets", 1'b1);
        edge_step(); grp_init = 1'b0;
        d = 1'b1; edge_step();
        sr_pt_set = 1'b1; #1 chk("R7 set line clears", 1'b0);
        sr_pt_clr = 1'b1; #1 chk("R8 swapped", 1'b1);
        edge_step(); chk("R8 swapped edge", 1'b1);
        sr_pt_set = 1'b0; sr_pt_clr = 1'b0;

        // R9 lines disabled
        power_on(1'b0, 1'b0, 0); d = 1'b1;
        edge_step();
        grp_init = 1'b1; sr_pt_clr = 1'b1; #1 chk("R9 clear ignored", 1'b1);
        edge_step(); chk("R9 clear ignored edge", 1'b1);
        grp_init = 1'b0; sr_pt_clr = 1'b0; d = 1'b0;
        edge_step();
        sr_pt_set = 1'b1; #1 chk("R9 set ignored", 1'b0);
        edge_step(); chk("R9 set ignored edge", 1'b0);
        sr_pt_set = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule